// File: doc/BRIEF.md
# Parallel Code-Store Programming Controller

This block drives the parallel programming and verify path of a small on-chip code store, held here as an internal register array of bytes. An external programmer selects an operation with a two-bit supply-level input and four mode-select pins. It pulses an active-low program strobe to start an operation, and pulses an increment input to step through addresses. Data enters on one byte bus and leaves on another, which is qualified by an output enable. A ready output goes low while a self-timed operation runs.

A single internal address counter serves every operation. Byte writes and lock-bit writes are self-timed over a parameterised number of clock cycles. A byte write can only clear bits, so the stored value becomes the old byte ANDed with the new data. Chip erase is triggered by holding the strobe low for a parameterised number of cycles. It restores every byte to FFH and clears both lock bits. While a byte write is still running, a read of that byte returns data polling: the inverted bit 7 and zeros below it. Two lock bits give three protection levels, and two fixed identification bytes can be read out.

All inputs are sampled on the rising clock edge. Reset `rst` is synchronous and active high. It puts the block in its as-delivered state: every byte is blank and both locks are open.

Top module: `fpc_prog_ctrl`

## Requirements
- R1: The address counter returns to 0 on the clock edge that first sees `prg_lvl` non-zero after having seen it at 00. This clear takes priority over an increment seen on the same edge.
- R2: The address counter advances by one on the clock edge that first sees `incr` high after it was low. It wraps from DEPTH-1 to 0.
- R3: After reset, every byte reads FFH, `rdy` is 1 and `data_oe` is 0.
- R4: A byte write starts on the edge that first sees `prog_n` high after it was low, when the mode is write-code, the block is idle and lock bit 1 is open. The address and `data_in` are captured on that edge. `rdy` is 0 for exactly WRITE_CYC cycles from that edge. The byte then holds old AND data.
- R5: While a byte write is running, a read-code access to the byte being written returns {~data[7], 7'b0}. After completion it returns the stored value.
- R6: Modes decode as follows. With `prg_lvl` of 10 or 11 (high voltage): `mode_sel` 1110 is write-code, 1111 is write-lock-1, 1100 is write-lock-2 and 0001 is chip erase. With `prg_lvl` 01 (logic high): 1100 is read-code and 0000 is read-signature. Every other combination is idle. `data_oe` is 1 only in the two read modes, and `data_out` is 00H when `data_oe` is 0.
- R7: With lock bit 1 set, a strobe in write-code mode starts nothing: `rdy` stays 1 and the array is unchanged.
- R8: With both lock bits set, read-code returns 00H. Read-signature is unaffected.
- R9: A strobe in a write-lock mode is self-timed like a byte write, then sets its lock bit. Only chip erase clears a lock bit.
- R10: In erase mode while idle, a low `prog_n` seen on ERASE_HOLD consecutive edges erases the array to FFH and clears both lock bits on the last of those edges. A shorter hold has no effect.
- R11: Read-signature returns 1EH at address 0, 22H at address 1, and 00H elsewhere.
- R12: While an operation runs, further strobes and mode changes do not alter it or start another, and its completion time is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the as-delivered state |
| prg_lvl | input | 2 | Supply level: 00 low, 01 logic high, 1x high voltage |
| mode_sel | input | 4 | Operation select pins |
| prog_n | input | 1 | Active-low program strobe |
| incr | input | 1 | Address increment pulse |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Byte read out |
| data_oe | output | 1 | Read data valid and driven |
| rdy | output | 1 | 1 when idle, 0 while a self-timed operation runs |

## Verification
The address counter, the strobe and increment edge detectors and the erase-hold counter are all one register deep. An increment, an address clear, an erase or the start of a write therefore shows up one clock edge after the stimulus is first seen. `data_out` and `data_oe` follow the mode pins and the counter combinationally. The `rdy` low window is checked at both ends: low after WRITE_CYC-1 further edges and high after the next edge. The bench drives inputs on the falling edge and samples the outputs on the falling edge, after the edge it has counted. The expected array contents are kept in an arithmetic model of the AND-write and erase rules.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int PEND_AW = 16;

    localparam logic [3:0] SEL_WR_CODE = 4'b1110;
    localparam logic [3:0] SEL_WR_LB1  = 4'b1111;
    localparam logic [3:0] SEL_WR_LB2  = 4'b1100;
    localparam logic [3:0] SEL_ERASE   = 4'b0001;
    localparam logic [3:0] SEL_RD_CODE = 4'b1100;
    localparam logic [3:0] SEL_RD_SIG  = 4'b0000;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;
    localparam logic [7:0] SIG_BYTE0  = 8'h1E;
    localparam logic [7:0] SIG_BYTE1  = 8'h22;

    typedef enum logic [2:0] {
        M_IDLE, M_WR_CODE, M_RD_CODE, M_WR_LB1, M_WR_LB2, M_ERASE, M_RD_SIG
    } mode_e;

    typedef enum logic [1:0] {
        OP_CODE = 2'd0,
        OP_LB1  = 2'd1,
        OP_LB2  = 2'd2
    } op_e;

    typedef struct packed {
        op_e                 op;
        logic [PEND_AW-1:0]  addr;
        logic [7:0]          data;
    } pend_t;

    function automatic mode_e decode_mode(input logic [1:0] lvl, input logic [3:0] sel);
        mode_e m;
        m = M_IDLE;
        if (lvl[1]) begin
            case (sel)
                SEL_WR_CODE: m = M_WR_CODE;
                SEL_WR_LB1:  m = M_WR_LB1;
                SEL_WR_LB2:  m = M_WR_LB2;
                SEL_ERASE:   m = M_ERASE;
                default:     m = M_IDLE;
            endcase
        end else if (lvl == 2'b01) begin
            case (sel)
                SEL_RD_CODE: m = M_RD_CODE;
                SEL_RD_SIG:  m = M_RD_SIG;
                default:     m = M_IDLE;
            endcase
        end
        return m;
    endfunction

    function automatic logic [7:0] sig_byte(input logic [PEND_AW-1:0] a);
        logic [7:0] v;
        case (a)
            16'd0:   v = SIG_BYTE0;
            16'd1:   v = SIG_BYTE1;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fpc_addr_ctr.sv
module fpc_addr_ctr #(
    parameter int DEPTH = 2048,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [AW-1:0] addr_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            addr_q <= '0;
        end else if (inc_i) begin
            if (addr_q == LAST) begin
                addr_q <= '0;
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    assign addr_o = addr_q;

    // R2: an increment without clear moves the counter (never stuck)
    assert_inc_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i) |=> (addr_q != $past(addr_q)));

endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
    import fpc_pkg::*;
#(
    parameter int WRITE_CYC = 1200,
    localparam int CW = $clog2(WRITE_CYC + 1)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  pend_t  req_i,
    output logic   busy_o,
    output logic   commit_o,
    output pend_t  pend_o
);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    pend_t         pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(WRITE_CYC - 1);
            pend_q <= req_i;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o   = busy_q;
    assign commit_o = busy_q && (cnt_q == '0);
    assign pend_o   = pend_q;

    // R4: a start request puts the sequencer into the busy state
    assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_q);

    // R12: the captured operation stays frozen for the whole busy window
    assert_pend_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(pend_q));

endmodule

// File: rtl/fpc_store.sv
module fpc_store
    import fpc_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit_i,
    input  pend_t         pend_i,
    input  logic          erase_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic          lb1_o,
    output logic          lb2_o
);

    logic [7:0] mem_q [DEPTH];
    logic       lb1_q;
    logic       lb2_q;
    logic [AW-1:0] wr_addr;

    assign wr_addr = pend_i.addr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst || erase_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= BLANK_BYTE;
            end
        end else if (commit_i && pend_i.op == OP_CODE) begin
            mem_q[wr_addr] <= mem_q[wr_addr] & pend_i.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || erase_i) begin
            lb1_q <= 1'b0;
            lb2_q <= 1'b0;
        end else if (commit_i) begin
            if (pend_i.op == OP_LB1) lb1_q <= 1'b1;
            if (pend_i.op == OP_LB2) lb2_q <= 1'b1;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign lb1_o     = lb1_q;
    assign lb2_o     = lb2_q;

    // R9: a committed lock-1 write leaves lock bit 1 set
    assert_lb1_set_R9: assert property (@(posedge clk) disable iff (rst)
        (commit_i && pend_i.op == OP_LB1) |=> lb1_q);

    // R9: lock bits never fall except on an erase
    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(lb1_q) || $fell(lb2_q)) |-> $past(erase_i));

    // R10: erase leaves both lock bits open
    assert_erase_unlock_R10: assert property (@(posedge clk) disable iff (rst)
        erase_i |=> (!lb1_q && !lb2_q));

endmodule

// File: rtl/fpc_prog_ctrl.sv
module fpc_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int DEPTH      = 2048,
    parameter int WRITE_CYC  = 1200,
    parameter int ERASE_HOLD = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] prg_lvl,
    input  logic [3:0] mode_sel,
    input  logic       prog_n,
    input  logic       incr,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic       data_oe,
    output logic       rdy
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int HW = $clog2(ERASE_HOLD + 1);

    mode_e         mode;
    logic          lvl_q, prog_q, incr_q;
    logic          lvl_rise, prog_rise, incr_rise;
    logic [AW-1:0] addr;
    logic          busy, commit;
    pend_t         pend, req;
    logic          start_ok, start_go;
    logic          lb1, lb2;
    logic [7:0]    rd_data;
    logic          erase_cond, erase_go, hold_spent;
    logic [HW-1:0] hold_cnt;

    assign mode = decode_mode(prg_lvl, mode_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            prog_q <= 1'b1;
            incr_q <= 1'b1;
        end else begin
            lvl_q  <= (prg_lvl != 2'b00);
            prog_q <= prog_n;
            incr_q <= incr;
        end
    end

    assign lvl_rise  = (prg_lvl != 2'b00) && !lvl_q;
    assign prog_rise = prog_n && !prog_q;
    assign incr_rise = incr && !incr_q;

    fpc_addr_ctr #(.DEPTH(DEPTH)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (lvl_rise),
        .inc_i  (incr_rise),
        .addr_o (addr)
    );

    always_comb begin
        req      = '0;
        req.addr = PEND_AW'(addr);
        req.data = data_in;
        start_ok = 1'b0;
        case (mode)
            M_WR_CODE: begin req.op = OP_CODE; start_ok = !lb1; end
            M_WR_LB1:  begin req.op = OP_LB1;  start_ok = 1'b1; end
            M_WR_LB2:  begin req.op = OP_LB2;  start_ok = 1'b1; end
            default:   begin req.op = OP_CODE; start_ok = 1'b0; end
        endcase
    end

    assign start_go = prog_rise && !busy && start_ok;

    fpc_seq #(.WRITE_CYC(WRITE_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_go),
        .req_i    (req),
        .busy_o   (busy),
        .commit_o (commit),
        .pend_o   (pend)
    );

    assign erase_cond = (mode == M_ERASE) && !prog_n && !busy;
    assign erase_go   = erase_cond && !hold_spent && (hold_cnt == HW'(ERASE_HOLD - 1));

    always_ff @(posedge clk) begin
        if (rst || !erase_cond) begin
            hold_cnt   <= '0;
            hold_spent <= 1'b0;
        end else if (!hold_spent) begin
            if (erase_go) begin
                hold_spent <= 1'b1;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    fpc_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (commit),
        .pend_i    (pend),
        .erase_i   (erase_go),
        .rd_addr_i (addr),
        .rd_data_o (rd_data),
        .lb1_o     (lb1),
        .lb2_o     (lb2)
    );

    always_comb begin
        data_oe  = (mode == M_RD_CODE) || (mode == M_RD_SIG);
        data_out = 8'h00;
        if (mode == M_RD_SIG) begin
            data_out = sig_byte(PEND_AW'(addr));
        end else if (mode == M_RD_CODE) begin
            if (lb1 && lb2) begin
                data_out = 8'h00;
            end else if (busy && pend.op == OP_CODE && pend.addr == PEND_AW'(addr)) begin
                data_out = {~pend.data[7], 7'b0};
            end else begin
                data_out = rd_data;
            end
        end
    end

    assign rdy = !busy;

    // R1: a rising supply level clears the address counter
    assert_addr_clear_R1: assert property (@(posedge clk) disable iff (rst)
        lvl_rise |=> (addr == '0));

    // R7: a code write never begins while lock bit 1 is set
    assert_no_locked_write_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && pend.op == OP_CODE) |-> !lb1);

    // R6: read data is only driven at logic-high level
    assert_oe_level_R6: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (prg_lvl == 2'b01));

    // R10: erase never fires during a running operation
    assert_erase_idle_R10: assert property (@(posedge clk) disable iff (rst)
        erase_go |-> !busy);

endmodule

// File: tb/fpc_prog_ctrl_tb.sv
module fpc_prog_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int WCYC       = 6;
    localparam int EHOLD      = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] prg_lvl = 2'b00;
    logic [3:0] mode_sel = 4'b0000;
    logic       prog_n = 1'b1;
    logic       incr = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic       rdy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_mem [DEPTH];
    int cur_a = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpc_prog_ctrl #(.DEPTH(DEPTH), .WRITE_CYC(WCYC), .ERASE_HOLD(EHOLD)) dut_i (
        .clk(clk), .rst(rst), .prg_lvl(prg_lvl), .mode_sel(mode_sel),
        .prog_n(prog_n), .incr(incr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .rdy(rdy)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 3) & 255);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic session_start();
        @(negedge clk); prg_lvl = 2'b00;
        @(negedge clk); prg_lvl = 2'b01;
        @(negedge clk);
        cur_a = 0;
    endtask

    task automatic bump();
        incr = 1'b1; @(negedge clk);
        incr = 1'b0; @(negedge clk);
        cur_a = (cur_a + 1) % DEPTH;
    endtask

    task automatic read_mode();
        prg_lvl = 2'b01; mode_sel = 4'b1100; @(negedge clk);
    endtask

    task automatic strobe(input logic [1:0] lvl, input logic [3:0] sel, input logic [7:0] d);
        prg_lvl = lvl; mode_sel = sel; data_in = d; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic timed_op(input string req, input logic [1:0] lvl, input logic [3:0] sel,
                            input logic [7:0] d);
        strobe(lvl, sel, d);
        check(req, {7'b0, rdy}, 8'h00);
        tick(WCYC - 1);
        check(req, {7'b0, rdy}, 8'h00);
        tick(1);
        check(req, {7'b0, rdy}, 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R3: reset state
        check("R3 rdy", {7'b0, rdy}, 8'h01);
        check("R3 oe", {7'b0, data_oe}, 8'h00);

        // R3/R2: blank sweep over every address
        session_start();
        read_mode();
        for (int a = 0; a < DEPTH; a++) begin
            check("R3 blank", data_out, 8'hFF);
            bump();
        end

        // R4: program every address with a pattern, full rdy timing on each
        session_start();
        for (int a = 0; a < DEPTH; a++) begin
            timed_op("R4 write rdy", (a % 2 == 0) ? 2'b10 : 2'b11, 4'b1110, pat(a));
            exp_mem[a] = exp_mem[a] & pat(a);
            bump();
        end

        // R2: verify every byte, then wrap back to address 0
        session_start();
        read_mode();
        for (int a = 0; a < DEPTH; a++) begin
            check("R2 R4 verify", data_out, exp_mem[a]);
            check("R6 oe read", {7'b0, data_oe}, 8'h01);
            bump();
        end
        check("R2 wrap", data_out, exp_mem[0]);

        // R4 AND rule and R5 polling at address 3
        bump(); bump(); bump();
        strobe(2'b10, 4'b1110, 8'h0F);
        read_mode();
        check("R5 polling", data_out, 8'h80);
        tick(WCYC);
        exp_mem[3] = exp_mem[3] & 8'h0F;
        check("R5 true data", data_out, exp_mem[3]);
        check("R4 and", data_out, pat(3) & 8'h0F);

        // R1: clear has priority over a simultaneous increment
        bump(); bump();
        prg_lvl = 2'b00; @(negedge clk);
        prg_lvl = 2'b01; incr = 1'b1; @(negedge clk);
        incr = 1'b0; @(negedge clk);
        cur_a = 0;
        check("R1 clear", data_out, exp_mem[0]);
        bump();
        check("R1 after clear inc", data_out, exp_mem[1]);

        // R12: second strobe and mode change during busy are ignored
        bump();
        strobe(2'b10, 4'b1110, 8'hF0);
        data_in = 8'h00; prog_n = 1'b0; mode_sel = 4'b0001; @(negedge clk);
        prog_n = 1'b1; mode_sel = 4'b1110; @(negedge clk);
        tick(WCYC - 3);
        check("R12 still busy", {7'b0, rdy}, 8'h00);
        tick(1);
        check("R12 done on time", {7'b0, rdy}, 8'h01);
        exp_mem[2] = exp_mem[2] & 8'hF0;
        read_mode();
        check("R12 value", data_out, exp_mem[2]);

        // R11: signature bytes
        session_start();
        prg_lvl = 2'b01; mode_sel = 4'b0000; @(negedge clk);
        check("R11 sig0", data_out, 8'h1E);
        bump();
        check("R11 sig1", data_out, 8'h22);
        bump();
        check("R11 sig2", data_out, 8'h00);

        // R6: non-read combinations leave the data port idle
        prg_lvl = 2'b01; mode_sel = 4'b1110; @(negedge clk);
        check("R6 oe wr-sel at logic", {7'b0, data_oe}, 8'h00);
        check("R6 data idle", data_out, 8'h00);
        prg_lvl = 2'b10; mode_sel = 4'b1100; @(negedge clk);
        check("R6 oe hv", {7'b0, data_oe}, 8'h00);

        // R9: lock bit 1 is self-timed; R7: then writes are blocked
        timed_op("R9 lb1 rdy", 2'b10, 4'b1111, 8'h00);
        session_start();
        bump(); bump(); bump(); bump();
        strobe(2'b10, 4'b1110, 8'h00);
        check("R7 no busy", {7'b0, rdy}, 8'h01);
        tick(WCYC);
        read_mode();
        check("R7 unchanged", data_out, exp_mem[4]);

        // R9: lock bit 2; R8: code read blocked, signature still served
        timed_op("R9 lb2 rdy", 2'b10, 4'b1100, 8'h00);
        read_mode();
        check("R8 locked read", data_out, 8'h00);
        session_start();
        prg_lvl = 2'b01; mode_sel = 4'b0000; @(negedge clk);
        check("R8 sig under lock", data_out, 8'h1E);

        // R10: short hold does nothing
        prg_lvl = 2'b10; mode_sel = 4'b0001; prog_n = 1'b0;
        tick(EHOLD - 1);
        prog_n = 1'b1; @(negedge clk);
        read_mode();
        check("R10 short hold", data_out, 8'h00);

        // R10: full hold erases array and locks
        prg_lvl = 2'b10; mode_sel = 4'b0001; prog_n = 1'b0;
        tick(EHOLD);
        prog_n = 1'b1; @(negedge clk);
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        session_start();
        read_mode();
        for (int a = 0; a < DEPTH; a++) begin
            check("R10 erased", data_out, 8'hFF);
            bump();
        end
        bump();
        timed_op("R10 R7 unlocked write", 2'b10, 4'b1110, 8'h5A);
        read_mode();
        check("R10 write after erase", data_out, 8'h5A);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule